// File: doc/BRIEF.md
# Memory-Mapped EEPROM Page-Buffer Controller

This block fronts a small on-chip EEPROM that sits permanently in the data address space. A read anywhere inside the data window returns the stored byte at that offset one cycle later, with no setup. A write into the same window does not touch the array. It fills one slot of a page buffer, chosen by the low address bits alone, and marks that slot as loaded.

Software commits the buffer with a short register sequence. It loads the page address into three byte registers and places a command code in the command register. It then writes the unlock key and strikes the go register within a short window. A commit either ANDs the loaded bytes into the page, or erases the page and then writes the loaded bytes as one step. While a commit runs the controller is busy for a fixed number of cycles. During that time it rejects every access except a status read. When the commit finishes, the buffer and its tags are cleared.

Top module: `eeprom_pgbuf_ctrl`

## Requirements
- R1: A read at 0x1000+n (n < 1024) returns EEPROM byte n on `bus_rdata` with `bus_rvalid` high in the cycle after the request. After reset every EEPROM byte is 0xFF, and after reset `bus_rvalid` and `bus_err` are low.
- R2: A write into the data window stores the byte in the buffer slot given by address bits [4:0] and tags that slot. Two writes to the same slot (for example 0x1015 and 0x1075) leave the later value.
- R3: Registers sit at 0x01C0+k: k=0 address low, k=1 address high, k=2 address top, k=3 command, k=4 key, k=5 go, k=6 status (bit 0 = busy). The committed page is bits [9:5] of {address high, address low}. Higher bits and the whole address-top register are ignored.
- R4: Command 0x34 (page write) replaces each tagged byte of the page with old AND buffer, and leaves untagged bytes unchanged.
- R5: Command 0x35 (erase-then-write) sets each tagged byte of the page to its buffer value and every untagged byte to 0xFF.
- R6: Command 0x36 (flush) clears all tags at once without going busy. The completion of any page commit also clears all tags.
- R7: An accepted page commit shows busy in status bit 0 for exactly BUSY_CYC cycles. A status read sampled in cycles 1..BUSY_CYC after the go write reads 1, and one sampled at cycle BUSY_CYC+1 reads 0.
- R8: While busy, a data-window read returns 0x00, and any data-window write or register write is dropped. Each such access raises a one-cycle `bus_err` in the cycle after the request.
- R9: A go write acts only if the key 0xD8 was written 1 to 4 cycles earlier. Without a key, or with the go write 5 or more cycles after it, nothing happens.
- R10: A go write with any command value other than 0x34, 0x35 or 0x36 does nothing, and it leaves the buffer and its tags intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address in the data space |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read response, one cycle after a read request |
| bus_err | output | 1 | Pulse: access rejected because the controller is busy |

## Verification
Every read response and every error pulse is due one clock edge after the request. The scoreboard therefore queues each expected read value when the request is driven and matches it against the first `bus_rvalid` it sees at the following falling edge. Error pulses are counted at falling edges, and their totals are compared only after at least one idle cycle has passed. Array contents after a commit are read back only after BUSY_CYC+2 idle cycles. The busy window itself is probed with status reads placed so that they sample exactly at the BUSY_CYC-th and (BUSY_CYC+1)-th edge after the go write.

// File: rtl/eepb_pkg.sv
package eepb_pkg;

   // command codes held in the command register
   localparam logic [7:0] CMD_PG_WRITE   = 8'h34;
   localparam logic [7:0] CMD_PG_ERWRITE = 8'h35;
   localparam logic [7:0] CMD_BUF_FLUSH  = 8'h36;

   // register offsets inside the 8-byte register block
   localparam logic [2:0] RO_ADR_LO = 3'd0;
   localparam logic [2:0] RO_ADR_HI = 3'd1;
   localparam logic [2:0] RO_ADR_TP = 3'd2;
   localparam logic [2:0] RO_CMD    = 3'd3;
   localparam logic [2:0] RO_KEY    = 3'd4;
   localparam logic [2:0] RO_GO     = 3'd5;
   localparam logic [2:0] RO_STAT   = 3'd6;

   typedef enum logic [1:0] {
      OP_IDLE    = 2'd0,
      OP_FLUSH   = 2'd1,
      OP_WRITE   = 2'd2,
      OP_ERWRITE = 2'd3
   } op_e;

endpackage

// File: rtl/eepb_regs.sv
module eepb_regs
   import eepb_pkg::*;
#(
   parameter int         KEY_WIN = 4,
   parameter logic [7:0] KEY_VAL = 8'hD8,
   localparam int        WIN_W   = $clog2(KEY_WIN + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_off,
   input  logic [7:0] wr_data,
   output logic [7:0] adr_lo_q,
   output logic [7:0] adr_hi_q,
   output logic [7:0] adr_tp_q,
   output logic [7:0] cmd_q,
   output op_e        op_go
);

   logic [WIN_W-1:0] win_q;
   logic             go_wr;
   logic             key_ok;
   logic             armed;

   assign go_wr  = wr_en && (wr_off == RO_GO);
   assign key_ok = wr_en && (wr_off == RO_KEY) && (wr_data == KEY_VAL);
   assign armed  = (win_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adr_lo_q <= '0;
         adr_hi_q <= '0;
         adr_tp_q <= '0;
         cmd_q    <= '0;
      end else if (wr_en) begin
         case (wr_off)
            RO_ADR_LO: adr_lo_q <= wr_data;
            RO_ADR_HI: adr_hi_q <= wr_data;
            RO_ADR_TP: adr_tp_q <= wr_data;
            RO_CMD:    cmd_q    <= wr_data;
            default:   ;
         endcase
      end
   end

   // unlock window: loaded by the key, consumed by go, otherwise runs down
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         win_q <= '0;
      else if (key_ok)
         win_q <= WIN_W'(KEY_WIN);
      else if (go_wr)
         win_q <= '0;
      else if (armed)
         win_q <= win_q - 1'b1;
   end

   always_comb begin
      op_go = OP_IDLE;
      if (go_wr && armed) begin
         case (cmd_q)
            CMD_PG_WRITE:   op_go = OP_WRITE;
            CMD_PG_ERWRITE: op_go = OP_ERWRITE;
            CMD_BUF_FLUSH:  op_go = OP_FLUSH;
            default:        op_go = OP_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/eepb_page_buf.sv
module eepb_page_buf #(
   parameter int  PAGE_BYTES = 32,
   localparam int SLOT_W     = $clog2(PAGE_BYTES)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [SLOT_W-1:0]          wr_slot,
   input  logic [7:0]                 wr_data,
   input  logic                       clr,
   output logic [PAGE_BYTES-1:0][7:0] buf_data,
   output logic [PAGE_BYTES-1:0]      buf_tag
);

   logic [7:0] data_q [PAGE_BYTES];
   logic       tag_q  [PAGE_BYTES];

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_slot == SLOT_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q[g] <= '0;
            tag_q[g]  <= 1'b0;
         end else if (clr) begin
            data_q[g] <= '0;
            tag_q[g]  <= 1'b0;
         end else if (hit) begin
            data_q[g] <= wr_data;
            tag_q[g]  <= 1'b1;
         end
      end

      assign buf_data[g] = data_q[g];
      assign buf_tag[g]  = tag_q[g];
   end

endmodule

// File: rtl/eepb_array.sv
module eepb_array #(
   parameter int         DEPTH      = 1024,
   parameter int         PAGE_BYTES = 32,
   parameter int         BUSY_CYC   = 64,
   parameter logic [7:0] ERASE_VAL  = 8'hFF,
   localparam int        OFF_W      = $clog2(DEPTH),
   localparam int        SLOT_W     = $clog2(PAGE_BYTES),
   localparam int        PG_W       = OFF_W - SLOT_W,
   localparam int        CNT_W      = $clog2(BUSY_CYC + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic                       erase,
   input  logic [PG_W-1:0]            page,
   input  logic [PAGE_BYTES-1:0][7:0] buf_data,
   input  logic [PAGE_BYTES-1:0]      buf_tag,
   input  logic [OFF_W-1:0]           rd_off,
   output logic [7:0]                 rd_byte,
   output logic                       busy,
   output logic                       done
);

   logic [7:0]      mem [DEPTH];
   logic [CNT_W-1:0] cnt_q;
   logic            busy_q;
   logic            erase_q;
   logic [PG_W-1:0] page_q;

   assign busy    = busy_q;
   assign done    = busy_q && (cnt_q == CNT_W'(1));
   assign rd_byte = mem[rd_off];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         erase_q <= 1'b0;
         page_q  <= '0;
      end else if (start && !busy_q) begin
         busy_q  <= 1'b1;
         cnt_q   <= CNT_W'(BUSY_CYC);
         erase_q <= erase;
         page_q  <= page;
      end else if (done) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // programming applied at the last busy cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= ERASE_VAL;
      end else if (done) begin
         for (int s = 0; s < PAGE_BYTES; s++) begin
            if (buf_tag[s])
               mem[{page_q, SLOT_W'(s)}] <= erase_q ? buf_data[s]
                                          : (mem[{page_q, SLOT_W'(s)}] & buf_data[s]);
            else if (erase_q)
               mem[{page_q, SLOT_W'(s)}] <= ERASE_VAL;
         end
      end
   end

endmodule

// File: rtl/eeprom_pgbuf_ctrl.sv
module eeprom_pgbuf_ctrl
   import eepb_pkg::*;
#(
   parameter int         ADDR_W     = 16,
   parameter int         WIN_BASE   = 'h1000,
   parameter int         REG_BASE   = 'h01C0,
   parameter int         DEPTH      = 1024,
   parameter int         PAGE_BYTES = 32,
   parameter int         BUSY_CYC   = 64,
   parameter int         KEY_WIN    = 4,
   parameter logic [7:0] KEY_VAL    = 8'hD8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              bus_rvalid,
   output logic              bus_err
);

   localparam int OFF_W  = $clog2(DEPTH);
   localparam int SLOT_W = $clog2(PAGE_BYTES);
   localparam int PG_W   = OFF_W - SLOT_W;

   // elaboration-time parameter checks
   if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 2) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two >= 2");
   end
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH <= PAGE_BYTES) begin : g_bad_depth
      $error("DEPTH must be a power of two larger than PAGE_BYTES");
   end
   if (OFF_W > 16) begin : g_bad_off
      $error("DEPTH must be addressable by two address bytes");
   end
   if (BUSY_CYC < 2) begin : g_bad_busy
      $error("BUSY_CYC must be at least 2");
   end
   if (KEY_WIN < 1) begin : g_bad_key
      $error("KEY_WIN must be at least 1");
   end
   if (REG_BASE + 8 > WIN_BASE && REG_BASE < WIN_BASE + DEPTH) begin : g_overlap
      $error("register block overlaps the data window");
   end

   // address decode
   logic              hit_win;
   logic              hit_reg;
   logic [OFF_W-1:0]  win_off;
   logic [2:0]        reg_off;
   logic              stat_rd;
   logic              busy;
   logic              done;
   logic              blocked;
   logic              acc_ok;

   assign hit_win = (bus_addr >= ADDR_W'(WIN_BASE)) && (bus_addr < ADDR_W'(WIN_BASE + DEPTH));
   assign hit_reg = (bus_addr >= ADDR_W'(REG_BASE)) && (bus_addr < ADDR_W'(REG_BASE + 8));
   assign win_off = OFF_W'(bus_addr - ADDR_W'(WIN_BASE));
   assign reg_off = 3'(bus_addr - ADDR_W'(REG_BASE));
   assign stat_rd = hit_reg && !bus_we && (reg_off == RO_STAT);
   assign blocked = bus_req && busy && (hit_win || (hit_reg && !stat_rd));
   assign acc_ok  = bus_req && !blocked;

   // registers and unlock
   logic [7:0] adr_lo, adr_hi, adr_tp, cmd;
   op_e        op_go;

   eepb_regs #(
      .KEY_WIN (KEY_WIN),
      .KEY_VAL (KEY_VAL)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (acc_ok && bus_we && hit_reg),
      .wr_off   (reg_off),
      .wr_data  (bus_wdata),
      .adr_lo_q (adr_lo),
      .adr_hi_q (adr_hi),
      .adr_tp_q (adr_tp),
      .cmd_q    (cmd),
      .op_go    (op_go)
   );

   // page buffer
   logic [PAGE_BYTES-1:0][7:0] buf_data;
   logic [PAGE_BYTES-1:0]      buf_tag;

   eepb_page_buf #(
      .PAGE_BYTES (PAGE_BYTES)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (acc_ok && bus_we && hit_win),
      .wr_slot  (win_off[SLOT_W-1:0]),
      .wr_data  (bus_wdata),
      .clr      ((op_go == OP_FLUSH) || done),
      .buf_data (buf_data),
      .buf_tag  (buf_tag)
   );

   // array and commit sequencer
   logic [15:0]     full_adr;
   logic [PG_W-1:0] page_sel;
   logic [7:0]      arr_byte;

   assign full_adr = {adr_hi, adr_lo};
   assign page_sel = full_adr[OFF_W-1:SLOT_W];

   eepb_array #(
      .DEPTH      (DEPTH),
      .PAGE_BYTES (PAGE_BYTES),
      .BUSY_CYC   (BUSY_CYC)
   ) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    ((op_go == OP_WRITE) || (op_go == OP_ERWRITE)),
      .erase    (op_go == OP_ERWRITE),
      .page     (page_sel),
      .buf_data (buf_data),
      .buf_tag  (buf_tag),
      .rd_off   (win_off),
      .rd_byte  (arr_byte),
      .busy     (busy),
      .done     (done)
   );

   // read mux and response registers
   logic [7:0] reg_byte;
   logic [7:0] rd_next;

   always_comb begin
      case (reg_off)
         RO_ADR_LO: reg_byte = adr_lo;
         RO_ADR_HI: reg_byte = adr_hi;
         RO_ADR_TP: reg_byte = adr_tp;
         RO_CMD:    reg_byte = cmd;
         RO_STAT:   reg_byte = {7'd0, busy};
         default:   reg_byte = 8'd0;
      endcase
   end

   always_comb begin
      if (blocked)      rd_next = 8'd0;
      else if (hit_win) rd_next = arr_byte;
      else if (hit_reg) rd_next = reg_byte;
      else              rd_next = 8'd0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
         bus_err    <= 1'b0;
      end else begin
         bus_rvalid <= bus_req && !bus_we;
         bus_rdata  <= (bus_req && !bus_we) ? rd_next : 8'd0;
         bus_err    <= blocked;
      end
   end

endmodule

// File: rtl/eepb_chk.sv
module eepb_chk #(
   parameter int ADDR_W   = 16,
   parameter int WIN_BASE = 'h1000,
   parameter int REG_BASE = 'h01C0,
   parameter int DEPTH    = 1024,
   parameter int BUSY_CYC = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_rdata,
   input logic              bus_rvalid,
   input logic              bus_err,
   input logic              busy
);

   localparam int CW = $clog2(BUSY_CYC + 2);

   logic          in_win;
   logic          go_wr;
   logic          busy_d;
   logic [CW-1:0] run_cnt;

   assign in_win = (bus_addr >= ADDR_W'(WIN_BASE)) && (bus_addr < ADDR_W'(WIN_BASE + DEPTH));
   assign go_wr  = bus_req && bus_we && (bus_addr == ADDR_W'(REG_BASE + 5));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_d  <= 1'b0;
         run_cnt <= '0;
      end else begin
         busy_d <= busy;
         if (busy && !busy_d) run_cnt <= CW'(1);
         else if (busy)       run_cnt <= run_cnt + 1'b1;
      end
   end

   // R1: a read response follows only a read request
   p_rvalid_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(bus_req && !bus_we));

   // R8: a blocked window read answers zero and flags an error
   p_busy_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_req && !bus_we && in_win) |=> (bus_rvalid && bus_rdata == 8'd0 && bus_err));

   // R8: an error pulse follows only a request made while busy
   p_err_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(bus_req && busy));

   // R9: a commit starts only on a go write
   p_start_on_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(go_wr));

   // R7: busy lasts exactly BUSY_CYC cycles
   p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && busy_d) |-> (run_cnt == CW'(BUSY_CYC)));

endmodule

bind eeprom_pgbuf_ctrl eepb_chk #(
   .ADDR_W   (ADDR_W),
   .WIN_BASE (WIN_BASE),
   .REG_BASE (REG_BASE),
   .DEPTH    (DEPTH),
   .BUSY_CYC (BUSY_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_req    (bus_req),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .bus_rvalid (bus_rvalid),
   .bus_err    (bus_err),
   .busy       (busy)
);

// File: tb/sim_eeprom_pgbuf_ctrl.sv
module sim_eeprom_pgbuf_ctrl;

   localparam int BUSY = 16;
   localparam logic [15:0] RB = 16'h01C0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        bus_rvalid;
   logic        bus_err;

   always #5 clk = ~clk;

   eeprom_pgbuf_ctrl #(.BUSY_CYC(BUSY)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .bus_err(bus_err)
   );

   typedef struct { logic [7:0] v; string t; } exp_t;
   exp_t exp_q [$];
   int total = 0;
   int bad = 0;
   int err_seen = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data as responses arrive
   always @(negedge clk) begin
      if (rst_n && bus_err) err_seen++;
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            total++; bad++;
            $display("FAIL R1 unexpected response actual=%0h expected=none", bus_rdata);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.t, bus_rdata, e.v);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
      exp_t x;
      x.v = e; x.t = t;
      exp_q.push_back(x);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
   endtask

   task automatic setup(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] tp,
                        input logic [7:0] c);
      wr(RB + 16'd0, lo); wr(RB + 16'd1, hi); wr(RB + 16'd2, tp); wr(RB + 16'd3, c);
   endtask

   task automatic fire();
      wr(RB + 16'd4, 8'hD8); wr(RB + 16'd5, 8'h01);
   endtask

   task automatic commit(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] tp,
                         input logic [7:0] c);
      setup(lo, hi, tp, c); fire(); idle(BUSY + 2);
   endtask

   initial begin
      int e0;
      repeat (3) @(negedge clk);
      chk("R1 rvalid after reset", bus_rvalid, 0);
      chk("R1 err after reset", bus_err, 0);
      rst_n = 1'b1;
      idle(1);

      // R1: erased array visible through the window
      rd(16'h1000, 8'hFF, "R1 first byte erased");
      rd(16'h13FF, 8'hFF, "R1 last byte erased");

      // R5 / R2: erase-write page 1
      wr(16'h1035, 8'hA5); wr(16'h1023, 8'h77);
      commit(8'h20, 8'h00, 8'h00, 8'h35);
      rd(16'h1035, 8'hA5, "R5 tagged byte");
      rd(16'h1023, 8'h77, "R5 tagged byte 2");
      rd(16'h1020, 8'hFF, "R5 untagged erased");
      rd(16'h1015, 8'hFF, "R2 page 0 untouched");

      // R2 alias + R4 AND into existing data
      wr(16'h1015, 8'hF0); wr(16'h1075, 8'h0F);
      commit(8'h20, 8'h00, 8'h00, 8'h34);
      rd(16'h1035, 8'h05, "R4 AND with last aliased write (R2)");
      rd(16'h1023, 8'h77, "R4 untagged unchanged");

      // R6 flush
      wr(16'h1020, 8'h00);
      setup(8'h20, 8'h00, 8'h00, 8'h36); fire(); idle(1);
      rd(RB + 16'd6, 8'h00, "R6 flush not busy");
      commit(8'h20, 8'h00, 8'h00, 8'h34);
      rd(16'h1020, 8'hFF, "R6 flushed byte not programmed");

      // R6 auto clear after commit
      wr(16'h1005, 8'h11);
      commit(8'h80, 8'h00, 8'h00, 8'h35);
      rd(16'h1085, 8'h11, "R6 first commit");
      commit(8'h80, 8'h00, 8'h00, 8'h35);
      rd(16'h1085, 8'hFF, "R6 tags cleared after commit");

      // R3 page from bits [9:5], higher bits and top register ignored
      wr(16'h1002, 8'h5A);
      commit(8'h40, 8'h04, 8'h07, 8'h35);
      rd(16'h1042, 8'h5A, "R3 page select");
      rd(16'h1002, 8'hFF, "R3 page 0 untouched");

      // R7 / R8 busy behaviour
      wr(16'h1001, 8'h33);
      setup(8'hA0, 8'h00, 8'h00, 8'h35); fire();
      e0 = err_seen;
      rd(RB + 16'd6, 8'h01, "R7 busy after go");
      rd(16'h1000, 8'h00, "R8 read while busy");
      wr(16'h1000, 8'h00);
      wr(RB + 16'd0, 8'h55);
      idle(BUSY - 5);
      rd(RB + 16'd6, 8'h01, "R7 busy at last cycle");
      rd(RB + 16'd6, 8'h00, "R7 idle after window");
      idle(1);
      chk("R8 error pulses", err_seen - e0, 3);
      rd(RB + 16'd0, 8'hA0, "R8 register write dropped");
      rd(16'h10A1, 8'h33, "R8 commit result");
      rd(16'h10A0, 8'hFF, "R8 busy write not tagged");

      // R9 key window
      wr(16'h1006, 8'h42);
      setup(8'hC0, 8'h00, 8'h00, 8'h34);
      wr(RB + 16'd5, 8'h01); idle(1);
      rd(RB + 16'd6, 8'h00, "R9 go without key ignored");
      wr(RB + 16'd4, 8'hD8); idle(4); wr(RB + 16'd5, 8'h01); idle(1);
      rd(RB + 16'd6, 8'h00, "R9 late go ignored");
      rd(16'h10C6, 8'hFF, "R9 page unchanged");
      wr(RB + 16'd4, 8'hD8); idle(3); wr(RB + 16'd5, 8'h01);
      rd(RB + 16'd6, 8'h01, "R9 go at window edge accepted");
      idle(BUSY + 2);
      rd(16'h10C6, 8'h42, "R9 commit result");

      // R10 invalid command
      wr(16'h1007, 8'h00);
      setup(8'hE0, 8'h00, 8'h00, 8'h55); fire(); idle(1);
      rd(RB + 16'd6, 8'h00, "R10 invalid command no busy");
      rd(16'h10E7, 8'hFF, "R10 page unchanged");
      commit(8'hE0, 8'h00, 8'h00, 8'h34);
      rd(16'h10E7, 8'h00, "R10 buffer kept");

      idle(3);
      if (exp_q.size() != 0) begin
         total++; bad++;
         $display("FAIL R1 missing responses actual=%0d expected=0", exp_q.size());
      end
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule